// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock Unit

This block resolves read-after-write dependences in a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). For the instruction in execute it picks, separately for each source operand, whether the value comes from the register file, from the memory-stage pipeline register, or from the writeback-stage pipeline register. For a store in the memory stage it says whether the store data must be replaced by a load result that is now in writeback. For the instruction in decode it flags sources that the writeback stage writes in the same cycle, so the register file read returns the new value.

When the instruction in decode needs the result of a load that is in execute, the unit raises a one-cycle interlock. The program counter and the fetch/decode register hold, and an empty slot with all control bits cleared goes into the decode/execute register. A store whose only dependence on that load is its store data is not held: the data is patched one stage later. Write-after-read and write-after-write orderings cannot occur in this pipeline, so only read-after-write matches are checked.

The hazard logic is combinational. It sits inside a thin registered wrapper: a word-index program counter and the four stage registers carrying register fields and control bits. Decoded fields of the fetched instruction enter at the fetch port. The register file, ALU, memories and branch resolution are outside the block.

Top module: `hz_fwd_unit`

## Requirements
- R1: `ex_fwd_a`/`ex_fwd_b` is 2 (take the memory-stage result) when the execute instruction uses that source and the memory-stage instruction writes (enable 1), is not a load, and has a nonzero destination equal to the source field.
- R2: If R1 does not apply, the select is 1 (take the writeback-stage result) when the source is used and the writeback-stage instruction writes a nonzero destination equal to it, load or not. Otherwise it is 0 (register file). Code 3 never appears.
- R3: When both the memory-stage and writeback-stage producers qualify for the same source, the memory-stage producer (code 2) wins.
- R4: A destination of register 0 never produces a forwarding select, a decode bypass, a store-data patch or an interlock.
- R5: A producer whose write enable is 0 never supplies a forwarded value, whatever its destination field holds.
- R6: `stall` is 1 when the execute instruction is a writing load with a nonzero destination and the decode instruction uses it as source 1, or as source 2 while not being a store. During that cycle `fetch_pc` and the fetch/decode register hold, and `stall` is never 1 in two cycles in a row for one load.
- R7: The empty slot inserted by an interlock never writes: three cycles after `stall`, `wb_wen` is 0.
- R8: A store that directly follows a load and takes its data from it is not stalled. `mem_st_fwd` is 1 when the memory-stage store uses source 2 and the writeback-stage instruction is a writing load whose nonzero destination equals that source.
- R9: `id_byp1`/`id_byp2` is 1 when the decode instruction uses that source and the writeback stage writes the same nonzero register.
- R10: A source whose use enable is 0 never causes a forwarding select, a bypass or an interlock.
- R11: After reset `fetch_pc` is 0, all selects and flags are 0, and `wb_wen` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| if_rs1 | input | REG_W | Fetched instruction source 1 register |
| if_rs2 | input | REG_W | Fetched instruction source 2 register |
| if_rd | input | REG_W | Fetched instruction destination register |
| if_src1_en | input | 1 | Fetched instruction reads source 1 |
| if_src2_en | input | 1 | Fetched instruction reads source 2 |
| if_wen | input | 1 | Fetched instruction writes its destination |
| if_load | input | 1 | Fetched instruction is a load |
| if_store | input | 1 | Fetched instruction is a store (source 2 is store data) |
| fetch_pc | output | PC_W | Word index of the instruction to fetch |
| stall | output | 1 | Load-use interlock: hold PC and fetch/decode, insert empty slot |
| ex_fwd_a | output | 2 | Execute source 1 select: 0 register file, 1 writeback, 2 memory stage |
| ex_fwd_b | output | 2 | Execute source 2 select, same coding |
| mem_st_fwd | output | 1 | Replace memory-stage store data with the writeback load result |
| id_byp1 | output | 1 | Decode source 1 is written by writeback this cycle |
| id_byp2 | output | 1 | Decode source 2 is written by writeback this cycle |
| wb_wen | output | 1 | Writeback-stage write enable |
| wb_rd | output | REG_W | Writeback-stage destination register |

## Verification
The assertions assume that the fetch fields are decoded consistently: a store has its write enable clear, a load has it set, and no instruction is both. The reset release must arrive away from the clock edge. The bench builds every instruction from a fixed set of kinds that meet these rules, and it drives the fetch port from the program entry chosen by `fetch_pc` half a cycle after each edge. Register numbers are limited to 0 to 3, and unused fields are filled with random values, so matches, register-0 cases and ignored fields all occur often.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef enum logic [1:0] {
    SEL_RF  = 2'd0,
    SEL_WB  = 2'd1,
    SEL_MEM = 2'd2
  } fwd_sel_e;

endpackage

// File: rtl/hz_operand_sel.sv
module hz_operand_sel
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             use_en,
  input  logic [REG_W-1:0] src,
  input  logic             mem_wen,
  input  logic             mem_load,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             wb_wen,
  input  logic [REG_W-1:0] wb_rd,
  output logic [1:0]       sel
);

  logic mem_hit;
  logic wb_hit;

  always_comb begin
    mem_hit = use_en && mem_wen && !mem_load && (mem_rd != '0) && (mem_rd == src);
    wb_hit  = use_en && wb_wen && (wb_rd != '0) && (wb_rd == src);
    if (mem_hit) begin
      sel = SEL_MEM;
    end else if (wb_hit) begin
      sel = SEL_WB;
    end else begin
      sel = SEL_RF;
    end
  end

endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] dec_rs1,
  input  logic [REG_W-1:0] dec_rs2,
  input  logic             dec_src1_en,
  input  logic             dec_src2_en,
  input  logic             dec_store,
  input  logic             ex_wen,
  input  logic             ex_load,
  input  logic [REG_W-1:0] ex_rd,
  output logic             stall
);

  logic ld_live;
  logic hit1;
  logic hit2;

  always_comb begin
    ld_live = ex_load && ex_wen && (ex_rd != '0);
    hit1    = dec_src1_en && (dec_rs1 == ex_rd);
    // store data is patched in the memory stage, so it does not interlock
    hit2    = dec_src2_en && !dec_store && (dec_rs2 == ex_rd);
    stall   = ld_live && (hit1 || hit2);
  end

endmodule

// File: rtl/hz_late_fwd.sv
module hz_late_fwd #(
  parameter int REG_W  = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][REG_W-1:0] dec_src,
  input  logic [NUM_SRC-1:0]            dec_src_en,
  input  logic                          mem_store,
  input  logic                          mem_src2_en,
  input  logic [REG_W-1:0]              mem_rs2,
  input  logic                          wb_wen,
  input  logic                          wb_load,
  input  logic [REG_W-1:0]              wb_rd,
  output logic [NUM_SRC-1:0]            dec_byp,
  output logic                          st_fwd
);

  logic wb_live;

  assign wb_live = wb_wen && (wb_rd != '0);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_byp
    assign dec_byp[g] = wb_live && dec_src_en[g] && (dec_src[g] == wb_rd);
  end

  assign st_fwd = wb_live && wb_load && mem_store && mem_src2_en && (mem_rs2 == wb_rd);

endmodule

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
  import hz_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int PC_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] if_rs1,
  input  logic [REG_W-1:0] if_rs2,
  input  logic [REG_W-1:0] if_rd,
  input  logic             if_src1_en,
  input  logic             if_src2_en,
  input  logic             if_wen,
  input  logic             if_load,
  input  logic             if_store,
  output logic [PC_W-1:0]  fetch_pc,
  output logic             stall,
  output logic [1:0]       ex_fwd_a,
  output logic [1:0]       ex_fwd_b,
  output logic             mem_st_fwd,
  output logic             id_byp1,
  output logic             id_byp2,
  output logic             wb_wen,
  output logic [REG_W-1:0] wb_rd
);

  localparam int NUM_SRC = 2;

  typedef struct packed {
    logic [REG_W-1:0] rs1;
    logic [REG_W-1:0] rs2;
    logic [REG_W-1:0] rd;
    logic             src1_en;
    logic             src2_en;
    logic             wen;
    logic             load;
    logic             store;
  } stage_t;

  logic [PC_W-1:0] pc_q, pc_d;
  stage_t ifid_q, ifid_d;
  stage_t idex_q, idex_d;
  stage_t exmem_q, exmem_d;
  stage_t memwb_q, memwb_d;
  logic front_en;

  // ---------------- hazard logic ----------------
  hz_load_use #(.REG_W(REG_W)) u_load_use (
    .dec_rs1     (ifid_q.rs1),
    .dec_rs2     (ifid_q.rs2),
    .dec_src1_en (ifid_q.src1_en),
    .dec_src2_en (ifid_q.src2_en),
    .dec_store   (ifid_q.store),
    .ex_wen      (idex_q.wen),
    .ex_load     (idex_q.load),
    .ex_rd       (idex_q.rd),
    .stall       (stall)
  );

  logic [NUM_SRC-1:0][REG_W-1:0] ex_src;
  logic [NUM_SRC-1:0]            ex_src_en;
  logic [NUM_SRC-1:0][1:0]       ex_sel;

  assign ex_src    = {idex_q.rs2, idex_q.rs1};
  assign ex_src_en = {idex_q.src2_en, idex_q.src1_en};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_opsel
    hz_operand_sel #(.REG_W(REG_W)) u_sel (
      .use_en   (ex_src_en[g]),
      .src      (ex_src[g]),
      .mem_wen  (exmem_q.wen),
      .mem_load (exmem_q.load),
      .mem_rd   (exmem_q.rd),
      .wb_wen   (memwb_q.wen),
      .wb_rd    (memwb_q.rd),
      .sel      (ex_sel[g])
    );
  end

  assign ex_fwd_a = ex_sel[0];
  assign ex_fwd_b = ex_sel[1];

  logic [NUM_SRC-1:0] dec_byp;

  hz_late_fwd #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_late (
    .dec_src     ({ifid_q.rs2, ifid_q.rs1}),
    .dec_src_en  ({ifid_q.src2_en, ifid_q.src1_en}),
    .mem_store   (exmem_q.store),
    .mem_src2_en (exmem_q.src2_en),
    .mem_rs2     (exmem_q.rs2),
    .wb_wen      (memwb_q.wen),
    .wb_load     (memwb_q.load),
    .wb_rd       (memwb_q.rd),
    .dec_byp     (dec_byp),
    .st_fwd      (mem_st_fwd)
  );

  assign id_byp1 = dec_byp[0];
  assign id_byp2 = dec_byp[1];

  // ---------------- next state ----------------
  assign front_en = !stall;

  always_comb begin
    pc_d           = pc_q + PC_W'(1);
    ifid_d.rs1     = if_rs1;
    ifid_d.rs2     = if_rs2;
    ifid_d.rd      = if_rd;
    ifid_d.src1_en = if_src1_en;
    ifid_d.src2_en = if_src2_en;
    ifid_d.wen     = if_wen;
    ifid_d.load    = if_load;
    ifid_d.store   = if_store;
    idex_d         = stall ? '0 : ifid_q;
    exmem_d        = idex_q;
    memwb_d        = exmem_q;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      ifid_q <= '0;
    end else if (front_en) begin
      pc_q   <= pc_d;
      ifid_q <= ifid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idex_q  <= '0;
      exmem_q <= '0;
      memwb_q <= '0;
    end else begin
      idex_q  <= idex_d;
      exmem_q <= exmem_d;
      memwb_q <= memwb_d;
    end
  end

  assign fetch_pc = pc_q;
  assign wb_wen   = memwb_q.wen;
  assign wb_rd    = memwb_q.rd;

endmodule

// File: rtl/hz_fwd_unit_chk.sv
module hz_fwd_unit_chk #(
  parameter int REG_W = 5,
  parameter int PC_W  = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stall,
  input logic [PC_W-1:0]  fetch_pc,
  input logic [1:0]       ex_fwd_a,
  input logic [1:0]       ex_fwd_b,
  input logic             mem_st_fwd,
  input logic             id_byp1,
  input logic             id_byp2,
  input logic             wb_wen,
  input logic [REG_W-1:0] wb_rd,
  input logic             exmem_load,
  input logic [REG_W-1:0] idex_rd
);

  AST_SEL_A_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    ex_fwd_a != 2'd3); // R2
  AST_SEL_B_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    ex_fwd_b != 2'd3); // R2
  AST_NO_LOAD_EARLY_A: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_fwd_a == 2'd2) |-> !exmem_load); // R1
  AST_NO_LOAD_EARLY_B: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_fwd_b == 2'd2) |-> !exmem_load); // R1
  AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall); // R6
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (fetch_pc == $past(fetch_pc))); // R6
  AST_STALL_RD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (idex_rd != '0)); // R4
  AST_BUBBLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> ##3 !wb_wen); // R7
  AST_STORE_PATCH_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    mem_st_fwd |-> (wb_wen && (wb_rd != '0))); // R8
  AST_BYP1_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    id_byp1 |-> (wb_wen && (wb_rd != '0))); // R9
  AST_BYP2_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    id_byp2 |-> (wb_wen && (wb_rd != '0))); // R9

endmodule

bind hz_fwd_unit hz_fwd_unit_chk #(.REG_W(REG_W), .PC_W(PC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stall      (stall),
  .fetch_pc   (fetch_pc),
  .ex_fwd_a   (ex_fwd_a),
  .ex_fwd_b   (ex_fwd_b),
  .mem_st_fwd (mem_st_fwd),
  .id_byp1    (id_byp1),
  .id_byp2    (id_byp2),
  .wb_wen     (wb_wen),
  .wb_rd      (wb_rd),
  .exmem_load (exmem_q.load),
  .idex_rd    (idex_q.rd)
);

// File: tb/hz_fwd_unit_tb.sv
module hz_fwd_unit_tb;

  localparam int REG_W = 5;
  localparam int PC_W  = 12;
  localparam int N     = 3000;

  logic             clk;
  logic             rst_n;
  logic [REG_W-1:0] if_rs1, if_rs2, if_rd;
  logic             if_src1_en, if_src2_en, if_wen, if_load, if_store;
  logic [PC_W-1:0]  fetch_pc;
  logic             stall;
  logic [1:0]       ex_fwd_a, ex_fwd_b;
  logic             mem_st_fwd, id_byp1, id_byp2, wb_wen;
  logic [REG_W-1:0] wb_rd;

  hz_fwd_unit #(.REG_W(REG_W), .PC_W(PC_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .if_rs1(if_rs1), .if_rs2(if_rs2), .if_rd(if_rd),
    .if_src1_en(if_src1_en), .if_src2_en(if_src2_en), .if_wen(if_wen),
    .if_load(if_load), .if_store(if_store),
    .fetch_pc(fetch_pc), .stall(stall),
    .ex_fwd_a(ex_fwd_a), .ex_fwd_b(ex_fwd_b), .mem_st_fwd(mem_st_fwd),
    .id_byp1(id_byp1), .id_byp2(id_byp2), .wb_wen(wb_wen), .wb_rd(wb_rd)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  int p_rs1[N], p_rs2[N], p_rd[N];
  bit p_s1[N], p_s2[N], p_wen[N], p_ld[N], p_st[N];

  int m_pc, m_ifid, m_idex, m_exm, m_mwb;
  bit e_stall;
  int c_stall = 0, c_st = 0, c_sel2 = 0, c_sel1 = 0, c_prio = 0, c_byp = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (pc model %0d)", tag, act, exp, m_pc);
    end
  endtask

  // kinds: 0 reg-reg ALU, 1 load, 2 store, 3 compare (no write), 4 reg-imm ALU
  task automatic set_ins(input int i, input int kind, input int rd, input int a, input int b);
    p_rd[i] = rd; p_rs1[i] = a; p_rs2[i] = b;
    p_s1[i] = 1; p_s2[i] = (kind == 0 || kind == 2 || kind == 3);
    p_wen[i] = (kind == 0 || kind == 1 || kind == 4);
    p_ld[i] = (kind == 1); p_st[i] = (kind == 2);
  endtask

  function automatic int g_rd(int i);  return (i < 0) ? 0 : p_rd[i];  endfunction
  function automatic int g_rs1(int i); return (i < 0) ? 0 : p_rs1[i]; endfunction
  function automatic int g_rs2(int i); return (i < 0) ? 0 : p_rs2[i]; endfunction
  function automatic bit g_s1(int i);  return (i < 0) ? 0 : p_s1[i];  endfunction
  function automatic bit g_s2(int i);  return (i < 0) ? 0 : p_s2[i];  endfunction
  function automatic bit g_wen(int i); return (i < 0) ? 0 : p_wen[i]; endfunction
  function automatic bit g_ld(int i);  return (i < 0) ? 0 : p_ld[i];  endfunction
  function automatic bit g_st(int i);  return (i < 0) ? 0 : p_st[i];  endfunction

  // R1 R2 R3 R4 R5 R10 expected execute select
  function automatic int exp_sel(bit use_en, int src, output bit both);
    bit mh, wh;
    mh = use_en && g_wen(m_exm) && !g_ld(m_exm) && g_rd(m_exm) != 0 && g_rd(m_exm) == src;
    wh = use_en && g_wen(m_mwb) && g_rd(m_mwb) != 0 && g_rd(m_mwb) == src;
    both = mh && wh;
    return mh ? 2 : (wh ? 1 : 0);
  endfunction

  task automatic drive(input int i);
    if (i >= 0 && i < N) begin
      if_rs1 = REG_W'(p_rs1[i]); if_rs2 = REG_W'(p_rs2[i]); if_rd = REG_W'(p_rd[i]);
      if_src1_en = p_s1[i]; if_src2_en = p_s2[i]; if_wen = p_wen[i];
      if_load = p_ld[i]; if_store = p_st[i];
    end else begin
      if_rs1 = '0; if_rs2 = '0; if_rd = '0;
      if_src1_en = 0; if_src2_en = 0; if_wen = 0; if_load = 0; if_store = 0;
    end
  endtask

  task automatic build_prog();
    logic [15:0] lf;
    bit lsb;
    // directed prefix
    set_ins(0, 1, 1, 2, 3);   // load r1
    set_ins(1, 0, 2, 1, 3);   // use r1 right after: interlock
    set_ins(2, 1, 1, 2, 0);   // load r1
    set_ins(3, 2, 0, 2, 1);   // store data r1: no interlock, patched later
    set_ins(4, 0, 3, 0, 0);   // write r3
    set_ins(5, 0, 3, 2, 2);   // write r3 again
    set_ins(6, 0, 2, 3, 3);   // both producers match: newer wins
    set_ins(7, 1, 0, 2, 2);   // load to r0
    set_ins(8, 0, 1, 0, 0);   // reads r0: no interlock
    set_ins(9, 3, 1, 2, 2);   // rd field 1 but no write
    set_ins(10, 0, 2, 1, 1);  // r1 not forwarded from 9
    set_ins(11, 1, 2, 1, 1);  // load r2
    set_ins(12, 4, 3, 1, 2);  // unused source 2 equals r2: no interlock
    lf = 16'hACE1;
    for (int i = 13; i < N; i++) begin
      int r;
      lsb = lf[0]; lf = lf >> 1; if (lsb) lf ^= 16'hB400;
      r = int'(lf);
      set_ins(i, r % 5, (r >> 4) & 3, (r >> 6) & 3, (r >> 8) & 3);
    end
  endtask

  initial begin
    build_prog();
    rst_n = 1'b0;
    drive(-1);
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk("R11 fetch_pc", int'(fetch_pc), 0);
    chk("R11 stall", int'(stall), 0);
    chk("R11 ex_fwd_a", int'(ex_fwd_a), 0);
    chk("R11 ex_fwd_b", int'(ex_fwd_b), 0);
    chk("R11 mem_st_fwd", int'(mem_st_fwd), 0);
    chk("R11 id_byp", int'({id_byp1, id_byp2}), 0);
    chk("R11 wb_wen", int'(wb_wen), 0);
    rst_n = 1'b1;
    m_pc = 0; m_ifid = -1; m_idex = -1; m_exm = -1; m_mwb = -1;
    e_stall = 0;
    drive(0);
    while (m_pc < N + 6) begin
      bit bth;
      int ea, eb;
      bit est, eb1, eb2;
      @(posedge clk);
      m_mwb = m_exm;
      m_exm = m_idex;
      if (e_stall) begin
        m_idex = -1;
      end else begin
        m_idex = m_ifid;
        m_ifid = (m_pc < N) ? m_pc : -1;
        m_pc++;
      end
      @(negedge clk);
      chk("R6 fetch_pc follows interlock", int'(fetch_pc), m_pc % (1 << PC_W));
      // R6 R4 R10 interlock, R8 store-data exemption
      e_stall = g_ld(m_idex) && g_wen(m_idex) && g_rd(m_idex) != 0 &&
                ((g_s1(m_ifid) && g_rs1(m_ifid) == g_rd(m_idex)) ||
                 (g_s2(m_ifid) && !g_st(m_ifid) && g_rs2(m_ifid) == g_rd(m_idex)));
      chk("R6 R4 R8 R10 stall", int'(stall), int'(e_stall));
      ea = exp_sel(g_s1(m_idex), g_rs1(m_idex), bth);
      if (bth) c_prio++;
      chk("R1 R2 R3 R4 R5 R10 ex_fwd_a", int'(ex_fwd_a), ea);
      eb = exp_sel(g_s2(m_idex), g_rs2(m_idex), bth);
      if (bth) c_prio++;
      chk("R1 R2 R3 R4 R5 R10 ex_fwd_b", int'(ex_fwd_b), eb);
      est = g_st(m_exm) && g_s2(m_exm) && g_wen(m_mwb) && g_ld(m_mwb) &&
            g_rd(m_mwb) != 0 && g_rd(m_mwb) == g_rs2(m_exm);
      chk("R8 mem_st_fwd", int'(mem_st_fwd), int'(est));
      eb1 = g_s1(m_ifid) && g_wen(m_mwb) && g_rd(m_mwb) != 0 && g_rd(m_mwb) == g_rs1(m_ifid);
      eb2 = g_s2(m_ifid) && g_wen(m_mwb) && g_rd(m_mwb) != 0 && g_rd(m_mwb) == g_rs2(m_ifid);
      chk("R9 id_byp1", int'(id_byp1), int'(eb1));
      chk("R9 id_byp2", int'(id_byp2), int'(eb2));
      chk("R7 wb_wen", int'(wb_wen), int'(g_wen(m_mwb)));
      if (g_wen(m_mwb)) chk("R7 wb_rd", int'(wb_rd), g_rd(m_mwb));
      if (e_stall) c_stall++;
      if (est) c_st++;
      if (ea == 2 || eb == 2) c_sel2++;
      if (ea == 1 || eb == 1) c_sel1++;
      if (eb1 || eb2) c_byp++;
      drive(m_pc);
    end
    // stimulus reached every case
    chk("R6 interlocks seen", int'(c_stall > 10), 1);
    chk("R8 store patches seen", int'(c_st > 3), 1);
    chk("R1 memory-stage forwards seen", int'(c_sel2 > 10), 1);
    chk("R2 writeback forwards seen", int'(c_sel1 > 10), 1);
    chk("R3 priority cases seen", int'(c_prio > 3), 1);
    chk("R9 bypasses seen", int'(c_byp > 10), 1);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R6 run did not end actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule